// File: doc/BRIEF.md
# Serial Transceiver Bring-Up Sequencer over Clause-45 Management

This block brings a 10G serial transceiver into a manually tuned SFI/XFI operating mode without any software involvement. It contains a small Clause-45 management master that drives the clock and data lines of the management bus. On a start pulse it walks a fixed list of seven register writes. Each write is sent as an address frame followed by a write frame.

The list runs in this order: device soft reset, reference-clock choice, auto-negotiation off, link training off, manual override of the trained link settings, receive equaliser setup, and a datapath reset. Two inputs supply the variable parts of the list. One picks the reference clock; the other group gives the equaliser tracking and pre-emphasis settings. When the last frame has left the bus, the block counts a long settling interval. It then raises a link-ready flag, and the traffic generator waits for that flag before it sends anything.

The data line is driven in open-drain fashion. The enable pulls the line low only for zero bits, and the line is released otherwise.

Top module: `mdio_bringup_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are as follows: `mdc_o` low, `mdio_oe_o` low, `mdio_o` high and `link_ready_o` low.
- R2: `mdc_o` toggles every `MDC_HALF` system clocks. Elaboration rejects any setting where `CLK_HZ/(2*MDC_HALF)` exceeds 2.5 MHz.
- R3: Every frame is 64 bits, sent MSB first:
  - 32 ones;
  - start bits `00`;
  - a 2-bit opcode: `00` for an address frame, `01` for a write frame;
  - the 5-bit port address `PRTAD`;
  - the 5-bit device address;
  - turnaround `10`;
  - 16 bits: the register address in an address frame, the write value in a write frame.

  Bits change only on a falling edge of `mdc_o` and stay stable across the rising edge.
- R4: `mdio_oe_o` is high only while a zero bit is being sent. An idle line is released, with `mdio_o` high and the enable low.
- R5: A start pulse produces exactly 14 frames, back to back. They cover seven steps, each sent as an address frame and then a write frame, in this order. Each step is given as (device, register, value), all in hex:
  - (1E, 0000, 8000)
  - (1E, 001D, see R6)
  - (07, 0000, 0000)
  - (01, 0096, 0000)
  - (1E, 8020, 03FF)
  - (1E, 0004, see R7)
  - (1E, 000E, 0008)
- R6: The step-2 value is `refclk_sel_i` placed in bit 12, with all other bits zero. 0 selects 156.25 MHz and 1 selects 312.5 MHz.
- R7: The step-6 value is `{eq_track_i, eq_pre_i[2:0], 12'h500}`. Tracking on with pre-emphasis 3'b101 gives 16'hD500.
- R8: `link_ready_o` stays low for the whole sequence. It rises between `SETTLE_CYC` and `SETTLE_CYC + 2*MDC_HALF + 8` system clocks after the rising `mdc_o` edge that samples the last bit of the final frame.
- R9: `link_ready_o` stays high until the next start pulse. That pulse drops it on the following clock and restarts the full sequence.
- R10: A start pulse that arrives while the sequence or the settle count is running is ignored. The frame stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins the bring-up sequence |
| refclk_sel_i | input | 1 | Reference clock choice: 0 = 156.25 MHz, 1 = 312.5 MHz |
| eq_track_i | input | 1 | Equaliser tracking enable, written to bit 15 of step 6 |
| eq_pre_i | input | 3 | Equaliser pre-emphasis code, written to bits 14:12 of step 6 |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data value (high when released) |
| mdio_oe_o | output | 1 | Open-drain pull-low enable for the data line |
| link_ready_o | output | 1 | Asserted once settling has completed |

## Verification
The checker assumes two things about the inputs:
- `start_i` is a single-cycle pulse.
- `refclk_sel_i`, `eq_track_i` and `eq_pre_i` hold steady from the start pulse until `link_ready_o` rises, because the frame contents are formed from them live.

The stimulus changes these settings only while the block sits in the ready state. It sweeps every combination of the reference choice and equaliser fields, one full sequence each. It injects extra start pulses only in the middle of sequences, where they must be ignored, or in the ready state, where they must restart the sequence. The checker's timing properties on the bus clock and data edges depend on no input at all.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

   localparam int unsigned N_STEPS    = 7;
   localparam int unsigned N_FRAMES   = 2 * N_STEPS;
   localparam int unsigned FRAME_BITS = 64;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SEND,
      SQ_DRAIN,
      SQ_SETTLE,
      SQ_READY
   } seq_state_t;

   typedef struct packed {
      logic [4:0]  dev;
      logic [15:0] addr;
      logic [15:0] val;
   } reg_step_t;

   // One entry of the bring-up list; the order is the required programming order.
   function automatic reg_step_t step_of(input logic [2:0] idx,
                                         input logic       rsel,
                                         input logic       trk,
                                         input logic [2:0] pre);
      reg_step_t s;
      case (idx)
         3'd0:    s = '{dev: 5'h1E, addr: 16'h0000, val: 16'h8000};
         3'd1:    s = '{dev: 5'h1E, addr: 16'h001D, val: {3'b000, rsel, 12'h000}};
         3'd2:    s = '{dev: 5'h07, addr: 16'h0000, val: 16'h0000};
         3'd3:    s = '{dev: 5'h01, addr: 16'h0096, val: 16'h0000};
         3'd4:    s = '{dev: 5'h1E, addr: 16'h8020, val: 16'h03FF};
         3'd5:    s = '{dev: 5'h1E, addr: 16'h0004, val: {trk, pre, 12'h500}};
         default: s = '{dev: 5'h1E, addr: 16'h000E, val: 16'h0008};
      endcase
      return s;
   endfunction

   function automatic logic [FRAME_BITS-1:0] frame_of(input reg_step_t  s,
                                                      input logic       is_wr,
                                                      input logic [4:0] prt);
      return {32'hFFFF_FFFF, 2'b00, (is_wr ? 2'b01 : 2'b00), prt, s.dev,
              2'b10, (is_wr ? s.val : s.addr)};
   endfunction

endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
   parameter int unsigned HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc_o,
   output logic fall_tick_o
);
   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic mdc_q;
   logic wrap;

   generate
      if (HALF == 1) begin : g_toggle
         assign wrap = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (wrap) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
         assign wrap = (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc_q <= 1'b0;
      else if (wrap) mdc_q <= ~mdc_q;
   end

   assign mdc_o       = mdc_q;
   assign fall_tick_o = wrap & mdc_q;
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx #(
   parameter int unsigned FB = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall_tick_i,
   input  logic          ld_valid_i,
   input  logic [FB-1:0] ld_word_i,
   output logic          ld_take_o,
   output logic          busy_o,
   output logic          mdio_o,
   output logic          mdio_oe_o
);
   localparam int unsigned RW = $clog2(FB);

   logic [FB-1:0] sh_q;
   logic [RW-1:0] rem_q;
   logic          bit_q;
   logic          drv_q;

   assign ld_take_o = fall_tick_i && (rem_q == '0) && ld_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         rem_q <= '0;
         bit_q <= 1'b1;
         drv_q <= 1'b0;
      end else if (fall_tick_i) begin
         if (rem_q != '0) begin
            bit_q <= sh_q[FB-1];
            sh_q  <= sh_q << 1;
            rem_q <= rem_q - 1'b1;
         end else if (ld_valid_i) begin
            bit_q <= ld_word_i[FB-1];
            sh_q  <= ld_word_i << 1;
            rem_q <= RW'(FB - 1);
            drv_q <= 1'b1;
         end else begin
            bit_q <= 1'b1;
            drv_q <= 1'b0;
         end
      end
   end

   assign busy_o    = drv_q;
   assign mdio_o    = drv_q ? bit_q : 1'b1;
   assign mdio_oe_o = drv_q & ~bit_q;
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
   import mdio_seq_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       take_i,
   input  logic       busy_i,
   output logic       ld_valid_o,
   output logic [3:0] frame_idx_o,
   output logic       ready_o
);
   localparam int unsigned SW   = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [3:0]  LAST = 4'(N_FRAMES - 1);

   seq_state_t    st_q;
   logic [3:0]    idx_q;
   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         idx_q <= '0;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE, SQ_READY: if (start_i) begin
               st_q  <= SQ_SEND;
               idx_q <= '0;
            end
            SQ_SEND: if (take_i) begin
               if (idx_q == LAST) st_q  <= SQ_DRAIN;
               else               idx_q <= idx_q + 1'b1;
            end
            SQ_DRAIN: if (!busy_i) begin
               st_q  <= SQ_SETTLE;
               cnt_q <= '0;
            end
            SQ_SETTLE: begin
               if (cnt_q == SW'(SETTLE_CYC - 1)) st_q  <= SQ_READY;
               else                              cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign ld_valid_o  = (st_q == SQ_SEND);
   assign frame_idx_o = idx_q;
   assign ready_o     = (st_q == SQ_READY);
endmodule

// File: rtl/mdio_bringup_seq.sv
module mdio_bringup_seq
   import mdio_seq_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 156_250_000,
   parameter int unsigned MDC_MAX_HZ = 2_500_000,
   parameter int unsigned MDC_HALF   = 32,
   parameter logic [4:0]  PRTAD      = 5'h00,
   parameter int unsigned SETTLE_CYC = 312_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       refclk_sel_i,
   input  logic       eq_track_i,
   input  logic [2:0] eq_pre_i,
   output logic       mdc_o,
   output logic       mdio_o,
   output logic       mdio_oe_o,
   output logic       link_ready_o
);
   localparam int unsigned MDC_HZ = CLK_HZ / (2 * MDC_HALF);

   generate
      if (MDC_HALF < 1) begin : g_bad_half
         $error("MDC_HALF must be at least 1");
      end
      if (MDC_HZ > MDC_MAX_HZ) begin : g_bad_rate
         $error("management clock above the allowed maximum");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic                  fall_tick;
   logic                  ld_valid;
   logic                  ld_take;
   logic                  tx_busy;
   logic [3:0]            frame_idx;
   reg_step_t             cur_step;
   logic [FRAME_BITS-1:0] cur_word;

   mdc_clkgen #(.HALF(MDC_HALF)) u_clk (
      .clk         (clk),
      .rst_n       (rst_n),
      .mdc_o       (mdc_o),
      .fall_tick_o (fall_tick)
   );

   bringup_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .take_i      (ld_take),
      .busy_i      (tx_busy),
      .ld_valid_o  (ld_valid),
      .frame_idx_o (frame_idx),
      .ready_o     (link_ready_o)
   );

   always_comb begin
      cur_step = step_of(frame_idx[3:1], refclk_sel_i, eq_track_i, eq_pre_i);
      cur_word = frame_of(cur_step, frame_idx[0], PRTAD);
   end

   mdio_frame_tx #(.FB(FRAME_BITS)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_tick_i (fall_tick),
      .ld_valid_i  (ld_valid),
      .ld_word_i   (cur_word),
      .ld_take_o   (ld_take),
      .busy_o      (tx_busy),
      .mdio_o      (mdio_o),
      .mdio_oe_o   (mdio_oe_o)
   );
endmodule

// File: rtl/mdio_bringup_chk.sv
module mdio_bringup_chk #(
   parameter int unsigned MDC_HALF = 32
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic mdc_o,
   input logic mdio_o,
   input logic mdio_oe_o,
   input logic link_ready_o
);
   logic        mdc_q;
   logic        seen_q;
   int unsigned hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q  <= 1'b0;
         seen_q <= 1'b0;
         hold_q <= 0;
      end else begin
         mdc_q <= mdc_o;
         if (mdc_o != mdc_q) begin
            seen_q <= 1'b1;
            hold_q <= 0;
         end else if (hold_q < MDC_HALF) begin
            hold_q <= hold_q + 1;
         end
      end
   end

   // R2
   mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mdc_o != mdc_q) && seen_q) |-> (hold_q == MDC_HALF - 1));

   // R4
   od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe_o |-> !mdio_o);

   // R3
   data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_o != $past(mdio_o)) |-> ($past(mdc_o) && !mdc_o));

   // R8
   ready_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_ready_o |-> !mdio_oe_o);

   // R9
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_ready_o && !start_i) |=> link_ready_o);

   // R9
   ready_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_ready_o && start_i) |=> !link_ready_o);
endmodule

bind mdio_bringup_seq mdio_bringup_chk #(.MDC_HALF(MDC_HALF)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .mdc_o        (mdc_o),
   .mdio_o       (mdio_o),
   .mdio_oe_o    (mdio_oe_o),
   .link_ready_o (link_ready_o)
);

// File: tb/mdio_bringup_seq_tb.sv
module mdio_bringup_seq_tb;
   localparam int unsigned HALF   = 2;
   localparam int unsigned SETTLE = 50;
   localparam logic [4:0]  PRT    = 5'h03;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       refclk_sel_i = 1'b0;
   logic       eq_track_i = 1'b0;
   logic [2:0] eq_pre_i = 3'd0;
   logic       mdc_o, mdio_o, mdio_oe_o, link_ready_o;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   bit done    = 0;

   logic [31:0] exp_w [14];
   int   fno = 0;
   int   ones = 0;
   bit   cap = 0;
   int   nb = 0;
   logic [31:0] word = '0;
   int   last_rise = 0;
   logic mdc_prev = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mdio_bringup_seq #(
      .CLK_HZ(10_000_000), .MDC_HALF(HALF), .PRTAD(PRT), .SETTLE_CYC(SETTLE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .refclk_sel_i(refclk_sel_i),
      .eq_track_i(eq_track_i), .eq_pre_i(eq_pre_i), .mdc_o(mdc_o), .mdio_o(mdio_o),
      .mdio_oe_o(mdio_oe_o), .link_ready_o(link_ready_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected post-preamble words, built from R3, R5, R6 and R7.
   task automatic build_expect(input logic rs, input logic tk, input logic [2:0] pr);
      logic [4:0]  dv;
      logic [15:0] ra, vl;
      for (int s = 0; s < 7; s++) begin
         case (s)
            0: begin dv = 5'h1E; ra = 16'h0000; vl = 16'h8000; end
            1: begin dv = 5'h1E; ra = 16'h001D; vl = 16'(rs) << 12; end
            2: begin dv = 5'h07; ra = 16'h0000; vl = 16'h0000; end
            3: begin dv = 5'h01; ra = 16'h0096; vl = 16'h0000; end
            4: begin dv = 5'h1E; ra = 16'h8020; vl = 16'h03FF; end
            5: begin dv = 5'h1E; ra = 16'h0004;
                     vl = (16'(tk) << 15) | (16'(pr) << 12) | 16'h0500; end
            default: begin dv = 5'h1E; ra = 16'h000E; vl = 16'h0008; end
         endcase
         exp_w[2*s]   = {2'b00, 2'b00, PRT, dv, 2'b10, ra};
         exp_w[2*s+1] = {2'b00, 2'b01, PRT, dv, 2'b10, vl};
      end
   endtask

   // Frame decoder: samples the line on each rising management clock.
   always @(negedge clk) begin
      mdc_prev <= mdc_o;
      if (rst_n && mdc_o && !mdc_prev) begin
         // R4: enable only pulls low
         check(mdio_oe_o == !mdio_o, "R4 open-drain", {31'd0, mdio_oe_o}, {31'd0, !mdio_o});
         if (cap) begin
            word = {word[30:0], mdio_o};
            nb++;
            if (nb == 32) begin
               cap = 0;
               ones = 0;
               last_rise = cyc;
               if (fno < 14) begin
                  // R5 R6 R7 R3 frame contents and order
                  check(word == exp_w[fno], "R5 frame", word, exp_w[fno]);
                  // R8 ready stays low during the sequence
                  check(!link_ready_o, "R8 ready low in sequence", {31'd0, link_ready_o}, 32'd0);
               end else begin
                  check(0, "R10 extra frame", word, 32'd0);
               end
               fno++;
            end
         end else if (mdio_o) begin
            ones++;
         end else begin
            // R3 preamble of at least 32 ones before start bits
            check(ones >= 32, "R3 preamble", ones, 32);
            cap = 1;
            nb = 1;
            word = '0;
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   initial begin
      int t0;
      int wait_c;
      int cfg;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mdc_o == 1'b0 && mdio_oe_o == 1'b0 && mdio_o == 1'b1 && link_ready_o == 1'b0,
            "R1 reset outputs", {28'd0, mdc_o, mdio_oe_o, mdio_o, link_ready_o}, 32'h2);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(mdc_o == 1'b0 && mdio_oe_o == 1'b0 && link_ready_o == 1'b0,
            "R1 after release", {29'd0, mdc_o, mdio_oe_o, link_ready_o}, 32'd0);
      cfg = 0;
      for (int rs = 0; rs < 2; rs++) begin
         for (int tk = 0; tk < 2; tk++) begin
            for (int pr = 0; pr < 8; pr++) begin
               refclk_sel_i = rs[0];
               eq_track_i   = tk[0];
               eq_pre_i     = pr[2:0];
               build_expect(rs[0], tk[0], pr[2:0]);
               fno = 0;
               pulse_start();
               if (cfg > 0) begin
                  // R9 restart drops ready the clock after the pulse
                  check(!link_ready_o, "R9 restart drops ready", {31'd0, link_ready_o}, 32'd0);
               end
               if (cfg % 4 == 1) begin
                  // R10 start pulse in mid-sequence must be ignored
                  repeat (1500) @(negedge clk);
                  pulse_start();
               end
               while (fno < 14) @(negedge clk);
               t0 = last_rise;
               wait_c = 0;
               while (!link_ready_o && wait_c < SETTLE + 100) begin
                  @(negedge clk);
                  wait_c++;
               end
               // R8 settle window
               check(link_ready_o && (cyc - t0 >= SETTLE) && (cyc - t0 <= SETTLE + 2*HALF + 8),
                     "R8 settle window", cyc - t0, SETTLE);
               repeat (20) @(negedge clk);
               // R9 ready holds with no start
               check(link_ready_o, "R9 ready holds", {31'd0, link_ready_o}, 32'd1);
               check(fno == 14, "R10 frame count", fno, 14);
               cfg++;
            end
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule